// File: doc/BRIEF.md
# Byte FIFO with Selectable Request Threshold

This block is the byte queue that sits on one side of an asynchronous serial channel: a channel uses one copy on its receive side and a second copy on its transmit side. Software selects at run time whether the queue is deep, holding sixteen bytes, or shallow, acting as a single holding register. Any change of that selection empties the queue.

The block compares its fill count with a threshold picked by a three-bit select. It drives a single level-sensitive request that the surrounding logic may route to an interrupt controller or to a DMA engine. A parameter sets whether the copy is receive-style, requesting while the fill is at or above the threshold, or transmit-style, requesting while the fill is at or below it. Bytes are written with a push strobe and read with a pop strobe. The popped byte appears on a registered output in the cycle after the pop.

Top module: `uart_trig_fifo`

## Requirements
- R1: After reset the queue is in shallow mode and empty. The level is 0, the full flag is 0, overrun is 0 and the read data is 0. The receive-style request is 0 and the transmit-style request is 1.
- R2: In deep mode (fifo_en=1) the queue accepts 16 bytes. It then shows full=1 and level=16, and it returns the bytes in write order, each on pop_data one cycle after its pop.
- R3: In shallow mode (fifo_en=0) the queue holds one byte. full rises after a single accepted push.
- R4: A push while full, without a pop in the same cycle, is dropped. The stored contents and the level stay unchanged, and overrun goes to 1 and stays 1 until the next mode change.
- R5: A pop while empty leaves pop_data at its last value and leaves the level at 0.
- R6: When fifo_en differs from the current mode, the next clock edge switches the mode and empties the queue. That edge sets the level to 0 and clears overrun, and it ignores any push or pop in that cycle.
- R7: In deep mode trig_sel selects the threshold. Code 0 gives 2 entries, 1 gives 4, 2 gives 8, 3 gives 12 and 4 gives 14, and codes 5, 6 and 7 give 8, the same as code 2.
- R8: A receive-style copy (IS_RX=1) in deep mode drives req=1 exactly when level >= threshold.
- R9: A transmit-style copy (IS_RX=0) in deep mode drives req=1 exactly when level <= threshold.
- R10: In shallow mode a receive-style copy drives req equal to full, and a transmit-style copy drives req equal to empty.
- R11: A push and a pop in the same cycle on a full queue are both accepted. The level stays the same, and pop_data shows the oldest byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | 1 selects the 16-entry mode, 0 selects the one-entry mode |
| trig_sel | input | 3 | Threshold select code |
| push | input | 1 | Write strobe |
| push_data | input | DATA_W | Byte to write |
| pop | input | 1 | Read strobe |
| pop_data | output | DATA_W | Last byte read, registered |
| full | output | 1 | Fill equals the current capacity |
| empty | output | 1 | Fill is zero |
| level | output | $clog2(DEPTH+1) | Current fill count |
| req | output | 1 | Threshold request for an interrupt or DMA |
| overrun | output | 1 | Sticky flag for a dropped push |

## Verification
The bench builds two copies with the default DEPTH=16 and DATA_W=8, one with IS_RX=1 and one with IS_RX=0, and feeds both the same stimulus. Each fill level therefore shows the receive-style and the transmit-style comparison side by side. With sixteen entries, all five thresholds are distinct and differ from both 0 and full. This makes the boundary cycles on either side of each threshold observable, and it lets the bench cover the fallback codes, the shallow mode and the flush on a mode change in one run.

// File: rtl/utf_pkg.sv
package utf_pkg;

  typedef enum logic {
    SIDE_TX = 1'b0,
    SIDE_RX = 1'b1
  } side_e;

  // Entries needed to reach the selected fraction of a deep queue.
  function automatic int unsigned deep_threshold(input logic [2:0] code,
                                                 input int unsigned depth);
    case (code)
      3'd0:    return depth / 8;
      3'd1:    return depth / 4;
      3'd3:    return (depth * 3) / 4;
      3'd4:    return (depth * 7) / 8;
      default: return depth / 2;
    endcase
  endfunction

  // Threshold in force for the current mode and side.
  function automatic int unsigned active_threshold(input logic deep,
                                                   input logic [2:0] code,
                                                   input int unsigned depth,
                                                   input logic rx_side);
    if (deep) return deep_threshold(code, depth);
    return rx_side ? 1 : 0;
  endfunction

  function automatic int unsigned capacity(input logic deep,
                                           input int unsigned depth);
    return deep ? depth : 1;
  endfunction

endpackage

// File: rtl/utf_store.sv
module utf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end

  // R5: without an accepted read the output word is held
  a_r5_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/utf_ctrl.sv
module utf_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          push,
  input  logic          pop,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          overrun,
  output logic          deep
);

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cap;
  logic          flush, pop_ok, push_ok, push_drop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap       = CW'(utf_pkg::capacity(deep, DEPTH));
  assign full      = (count == cap);
  assign empty     = (count == '0);
  assign flush     = (fifo_en != deep);
  assign pop_ok    = pop && !empty && !flush;
  assign push_ok   = push && !flush && (!full || pop_ok);
  assign push_drop = push && !flush && !push_ok;

  assign wr_en   = push_ok;
  assign wr_addr = wr_ptr;
  assign rd_en   = pop_ok;
  assign rd_addr = rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deep    <= 1'b0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else if (flush) begin
      deep    <= fifo_en;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_drop) overrun <= 1'b1;
    end
  end

  // R2: fill never passes the capacity of the current mode
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R3: shallow mode never holds more than one byte
  a_r3_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
    !deep |-> count <= CW'(1));
  // R4: a dropped push leaves the fill untouched
  a_r4_drop_keeps_fill: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> count == $past(count));
  // R4: overrun is sticky until a mode change
  a_r4_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !flush |=> overrun);
  // R5: a pop on an empty queue without a push keeps it empty
  a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    pop && empty && !push |=> empty);
  // R6: a mode change empties the queue and clears overrun
  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty && !overrun);
  // R11: a paired push and pop keep the fill level
  a_r11_pair_level: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && pop_ok |=> count == $past(count));

endmodule

// File: rtl/utf_trigger.sv
module utf_trigger #(
  parameter int DEPTH  = 16,
  parameter bit IS_RX  = 1'b1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          deep,
  input  logic [2:0]    code,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] thr,
  output logic          req
);

  assign thr = CW'(utf_pkg::active_threshold(deep, code, DEPTH, IS_RX));

  generate
    if (IS_RX) begin : g_rx_side
      assign req = (count >= thr);
    end else begin : g_tx_side
      assign req = (count <= thr);
    end
  endgenerate

endmodule

// File: rtl/uart_trig_fifo.sv
module uart_trig_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter bit IS_RX  = 1'b1,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic [2:0]        trig_sel,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              full,
  output logic              empty,
  output logic [CW-1:0]     level,
  output logic              req,
  output logic              overrun
);

  logic          wr_en, rd_en, deep;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] count, thr;

  utf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .fifo_en (fifo_en),
    .push    (push),
    .pop     (pop),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .count   (count),
    .full    (full),
    .empty   (empty),
    .overrun (overrun),
    .deep    (deep)
  );

  utf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (push_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (pop_data)
  );

  utf_trigger #(.DEPTH(DEPTH), .IS_RX(IS_RX)) u_trig (
    .deep  (deep),
    .code  (trig_sel),
    .count (count),
    .thr   (thr),
    .req   (req)
  );

  assign level = count;

  // R1/R3: full and empty are never both set
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  generate
    if (IS_RX) begin : g_rx_checks
      // R10: shallow receive side requests exactly while holding its byte
      a_r10_shallow_rx: assert property (@(posedge clk) disable iff (!rst_n)
        !deep |-> req == full);
      // R8: a full deep queue is always over any threshold
      a_r8_full_requests: assert property (@(posedge clk) disable iff (!rst_n)
        deep && full |-> req);
    end else begin : g_tx_checks
      // R10: shallow transmit side requests exactly while it has room
      a_r10_shallow_tx: assert property (@(posedge clk) disable iff (!rst_n)
        !deep |-> req == empty);
      // R9: an empty deep queue is always under any threshold
      a_r9_empty_requests: assert property (@(posedge clk) disable iff (!rst_n)
        deep && empty |-> req);
    end
  endgenerate

endmodule

// File: tb/tb_uart_trig_fifo.sv
`timescale 1ns/1ps
module tb_uart_trig_fifo;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0;
  logic [2:0] trig_sel = 3'd0;
  logic       push = 1'b0, pop = 1'b0;
  logic [7:0] push_data = 8'h00;
  logic [7:0] rx_data, tx_data;
  logic       rx_full, rx_empty, rx_req, rx_ovr;
  logic       tx_full, tx_empty, tx_req, tx_ovr;
  logic [4:0] rx_level, tx_level;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_trig_fifo #(.DATA_W(8), .DEPTH(16), .IS_RX(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .push(push), .push_data(push_data), .pop(pop), .pop_data(rx_data),
    .full(rx_full), .empty(rx_empty), .level(rx_level), .req(rx_req),
    .overrun(rx_ovr));

  uart_trig_fifo #(.DATA_W(8), .DEPTH(16), .IS_RX(1'b0)) dut_tx (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .push(push), .push_data(push_data), .pop(pop), .pop_data(tx_data),
    .full(tx_full), .empty(tx_empty), .level(tx_level), .req(tx_req),
    .overrun(tx_ovr));

  // {code[2:0], fill[4:0], rx_req, tx_req}: expectations from R7, R8, R9
  localparam logic [9:0] VEC [16] = '{
    {3'd0, 5'd1,  1'b0, 1'b1}, {3'd0, 5'd2,  1'b1, 1'b1}, {3'd0, 5'd3,  1'b1, 1'b0},
    {3'd1, 5'd3,  1'b0, 1'b1}, {3'd1, 5'd4,  1'b1, 1'b1}, {3'd1, 5'd5,  1'b1, 1'b0},
    {3'd2, 5'd7,  1'b0, 1'b1}, {3'd2, 5'd8,  1'b1, 1'b1}, {3'd2, 5'd9,  1'b1, 1'b0},
    {3'd3, 5'd11, 1'b0, 1'b1}, {3'd3, 5'd12, 1'b1, 1'b1},
    {3'd4, 5'd14, 1'b1, 1'b1}, {3'd4, 5'd15, 1'b1, 1'b0},
    {3'd5, 5'd8,  1'b1, 1'b1}, {3'd6, 5'd9,  1'b1, 1'b0}, {3'd7, 5'd7,  1'b0, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one cycle from a falling edge; return at the next falling edge.
  task automatic cyc(input bit p, input logic [7:0] d, input bit q);
    push = p; push_data = d; pop = q;
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
  endtask

  task automatic drain();
    while (!rx_empty) cyc(1'b0, 8'h00, 1'b1);
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7 + 1);
  endfunction

  initial begin
    #(4 * 20000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 empty", rx_empty, 1);
    chk("R1 full", rx_full, 0);
    chk("R1 level", rx_level, 0);
    chk("R1 overrun", rx_ovr, 0);
    chk("R1 pop_data", rx_data, 0);
    chk("R1 rx req", rx_req, 0);
    chk("R1 tx req", tx_req, 1);

    // R3 / R10 shallow mode
    cyc(1'b1, 8'hA5, 1'b0);
    chk("R3 full after one push", rx_full, 1);
    chk("R3 level", rx_level, 1);
    chk("R10 rx req follows full", rx_req, 1);
    chk("R10 tx req follows empty", tx_req, 0);
    cyc(1'b1, 8'h3C, 1'b0);
    chk("R4 shallow overrun", rx_ovr, 1);
    chk("R4 shallow level", rx_level, 1);
    cyc(1'b0, 8'h00, 1'b1);
    chk("R4 stored byte kept", rx_data, 8'hA5);
    chk("R10 rx req empty", rx_req, 0);
    chk("R10 tx req empty", tx_req, 1);
    cyc(1'b0, 8'h00, 1'b1);
    chk("R5 pop on empty data", rx_data, 8'hA5);
    chk("R5 pop on empty level", rx_level, 0);

    // R6 enable change with a push in the same cycle
    fifo_en = 1'b1;
    cyc(1'b1, 8'h11, 1'b0);
    chk("R6 level after change", rx_level, 0);
    chk("R6 empty after change", rx_empty, 1);
    chk("R6 overrun cleared", rx_ovr, 0);

    // R2 deep fill
    for (int i = 0; i < 16; i++) cyc(1'b1, pat(i), 1'b0);
    chk("R2 full", rx_full, 1);
    chk("R2 level", rx_level, 16);
    // R11 paired push and pop while full
    cyc(1'b1, 8'hEE, 1'b1);
    chk("R11 level kept", rx_level, 16);
    chk("R11 oldest byte", rx_data, pat(0));
    // R4 deep overrun
    cyc(1'b1, 8'h77, 1'b0);
    chk("R4 deep overrun", rx_ovr, 1);
    chk("R4 deep level", rx_level, 16);
    for (int i = 1; i < 16; i++) begin
      cyc(1'b0, 8'h00, 1'b1);
      chk("R2 order", rx_data, pat(i));
    end
    cyc(1'b0, 8'h00, 1'b1);
    chk("R11 paired byte last", rx_data, 8'hEE);
    chk("R4 dropped byte absent", rx_empty, 1);
    chk("R4 overrun sticky", rx_ovr, 1);

    // R7 / R8 / R9 threshold table
    for (int v = 0; v < 16; v++) begin
      drain();
      trig_sel = VEC[v][9:7];
      for (int k = 0; k < int'(VEC[v][6:2]); k++) cyc(1'b1, 8'(k), 1'b0);
      @(negedge clk);
      chk("R7 R8 rx req", rx_req, VEC[v][1]);
      chk("R7 R9 tx req", tx_req, VEC[v][0]);
    end

    // R6 disable with content
    drain();
    for (int k = 0; k < 3; k++) cyc(1'b1, 8'(k), 1'b0);
    fifo_en = 1'b0;
    cyc(1'b0, 8'h00, 1'b1);
    chk("R6 flushed level", rx_level, 0);
    chk("R6 flushed overrun", rx_ovr, 0);
    chk("R10 rx req after disable", rx_req, 0);
    chk("R10 tx req after disable", tx_req, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule